// File: doc/BRIEF.md
# Bit-Manipulation Integer ALU

This block is the integer execution datapath of a 64-bit core. It takes a 7-bit operation code and two 64-bit sources and returns one 64-bit result. Its operations cover base and bit-manipulation shifts, rotates, single-bit updates, 32-bit word arithmetic with sign extension, shift-and-add address arithmetic, subtract-based compares with min and max, logic with an inverted second operand, byte and halfword packing, and a set of fused forms that cut a result down to one bit, a byte or a halfword.

The datapath itself is purely combinational. A single output register captures the result whenever `in_valid` is high, and `out_valid` follows one cycle later. Nothing can stall the block, so there is no ready signal and no back-pressure. A consumer must take each result in the cycle when `out_valid` is high. The upper three opcode bits select an operation group, and the lower four bits select the operation inside that group.

Top module: `bmalu_top`

## Requirements
- R1: When `in_valid` is high on a rising edge, the result of that operation appears on `result` after that edge and `out_valid` is high for one cycle. When `in_valid` is low, `out_valid` drops and `result` keeps its last value. Reset drives both outputs to zero.
- R2: Shift group 000, with amount n = src2[5:0]. The codes are: 0000 shifts the zero-extended src1[31:0] left by n; 0001 is a logical left shift; 0101 is a logical right shift; 0111 is an arithmetic right shift; 1001 rotates left; 1011 rotates right.
- R3: Single-bit operations in group 000, with index n = src2[5:0]. The codes are: 0010 clears bit n of src1; 0011 sets bit n; 0100 inverts bit n only; 0110 returns src1[n] in bit 0 and zero elsewhere.
- R4: Word group 001. The block forms a 32-bit value and sign-extends its bit 31 to 64 bits. The codes are: 0000 is the low-word sum; 0001 is src1[0] plus src2; 0010 is the low-word difference; 1000 shifts left by src2[4:0]; 1001 shifts src1[31:0] logically right; 1010 shifts src1[31:0] arithmetically right; 1100 rotates src1[31:0] left; 1101 rotates it right.
- R5: Fused word adds in group 001, all taken from src1+src2. The codes are: 0100 gives bit 0 of the sum; 0101 gives the zero-extended low byte; 0110 gives the zero-extended low halfword; 0111 gives the sign-extended low halfword.
- R6: Add group 010. The codes are: 0000 adds the zero-extended src1[31:0] to src2; 0001 adds src1 to src2; 0010 adds src1[0] to src2.
- R7: Shift-add in group 010. Codes 1001, 1011, 1101 and 1111 add src1 shifted left by 1, 2, 3 and 4 to src2. Codes 1000, 1010 and 1100 do the same with the zero-extended src1[31:0], shifted by 1, 2 and 3.
- R8: Codes 010_01kk add src1, logically shifted right by 29+kk, to src2.
- R9: Group 011 works from src1 minus src2. The codes are: 0000 returns the difference; 0001 is an unsigned less-than and 0010 a signed less-than, each giving 0 or 1; 0100 is the unsigned maximum; 0101 the unsigned minimum; 0110 the signed maximum; 0111 the signed minimum.
- R10: Logic group 100. The codes are: 0000 AND; 0001 AND with inverted src2; 0010 OR; 0011 OR with inverted src2; 0100 XOR; 0101 XNOR; 0110 replaces each byte of src1 with 0xFF if the byte is non-zero and with 0x00 if it is zero.
- R11: Packing and extension. The codes are: 100_1000 sign-extends src1[7:0]; 100_1001 gives {src2[7:0], src1[7:0]} zero-extended; 100_1010 sign-extends src1[15:0]; 100_1011 sign-extends {src2[15:0], src1[15:0]}; 101_0001 reverses the byte order of src1; 101_0010 gives {src2[31:0], src1[31:0]}.
- R12: Fused logic codes 110_0ffz. Field ff selects AND, OR, XOR, or the byte-OR-combine of src1 (00, 01, 10, 11). When z=0 the result keeps only bit 0; when z=1 it keeps the low 16 bits, zero-extended.
- R13: Every opcode not listed above produces a zero result. This includes all of group 111 and 110_1xxx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 7 | Operation code: group in [6:4], function in [3:0] |
| src1 | input | 64 | First source operand |
| src2 | input | 64 | Second source operand |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Registered result |

## Verification
The assertions assume that `in_valid` and `op` are never unknown while reset is released. They also assume that every operation is valid for exactly one cycle. The bench meets this by driving every input to a known value at each falling edge from reset onward. It walks all 128 opcode values, including the undefined ones, against operand patterns that reach shift amounts 0, 31, 32 and 63, sign-bit mixes and pseudo-random words. It also inserts idle cycles to exercise the hold behaviour.

// File: rtl/bmalu_pkg.sv
package bmalu_pkg;
  parameter int XLEN_DEF = 64;
  parameter int WORD_W   = 32;
  parameter int OP_W     = 7;

  typedef enum logic [2:0] {
    GRP_SHIFT = 3'b000,
    GRP_WORD  = 3'b001,
    GRP_ADD   = 3'b010,
    GRP_CMP   = 3'b011,
    GRP_LOGIC = 3'b100,
    GRP_MISC  = 3'b101,
    GRP_FUSED = 3'b110,
    GRP_NONE  = 3'b111
  } alu_grp_e;
endpackage

// File: rtl/bm_shift_unit.sv
module bm_shift_unit #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [3:0]              fn,
  input  logic [XLEN-1:0]         src1,
  input  logic [$clog2(XLEN)-1:0] shamt,
  output logic [XLEN-1:0]         base_res,
  output logic [XLEN-1:0]         word_res
);
  localparam int SHW  = $clog2(XLEN);
  localparam int WSHW = $clog2(WLEN);

  logic [XLEN-1:0] bit_mask;
  genvar gi;
  generate
    for (gi = 0; gi < XLEN; gi++) begin : g_mask
      assign bit_mask[gi] = (shamt == SHW'(gi));
    end
  endgenerate

  logic [SHW-1:0]  neg_amt;
  logic [XLEN-1:0] lo_zext, shl_v, shr_v, sra_v, rotl_v, rotr_v;

  assign neg_amt = SHW'(0) - shamt;
  assign lo_zext = {{(XLEN-WLEN){1'b0}}, src1[WLEN-1:0]};
  assign shl_v   = src1 << shamt;
  assign shr_v   = src1 >> shamt;
  assign sra_v   = $signed(src1) >>> shamt;
  assign rotl_v  = (src1 << shamt) | (src1 >> neg_amt);
  assign rotr_v  = (src1 >> shamt) | (src1 << neg_amt);

  always_comb begin
    case (fn)
      4'b0000: base_res = lo_zext << shamt;
      4'b0001: base_res = shl_v;
      4'b0010: base_res = src1 & ~bit_mask;
      4'b0011: base_res = src1 | bit_mask;
      4'b0100: base_res = src1 ^ bit_mask;
      4'b0101: base_res = shr_v;
      4'b0110: base_res = {{(XLEN-1){1'b0}}, |(src1 & bit_mask)};
      4'b0111: base_res = sra_v;
      4'b1001: base_res = rotl_v;
      4'b1011: base_res = rotr_v;
      default: base_res = '0;
    endcase
  end

  logic [WSHW-1:0] wamt, wneg;
  logic [WLEN-1:0] wsrc, wres;
  assign wamt = shamt[WSHW-1:0];
  assign wneg = WSHW'(0) - wamt;
  assign wsrc = src1[WLEN-1:0];

  always_comb begin
    case (fn)
      4'b1000: wres = wsrc << wamt;
      4'b1001: wres = wsrc >> wamt;
      4'b1010: wres = $signed(wsrc) >>> wamt;
      4'b1100: wres = (wsrc << wamt) | (wsrc >> wneg);
      4'b1101: wres = (wsrc >> wamt) | (wsrc << wneg);
      default: wres = '0;
    endcase
  end

  assign word_res = {{(XLEN-WLEN){wres[WLEN-1]}}, wres};
endmodule

// File: rtl/bm_add_unit.sv
module bm_add_unit #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [3:0]      fn,
  input  logic [XLEN-1:0] src1,
  input  logic [XLEN-1:0] src2,
  output logic [XLEN-1:0] add_res,
  output logic [XLEN-1:0] word_res
);
  localparam int SR_BASE = 29;
  localparam int HALF    = 16;
  localparam int BYTE    = 8;

  logic [XLEN-1:0] lo_zext, opnd_a, sum_sel, sum_raw, odd_sum;
  logic [WLEN-1:0] wdiff;
  logic            opnd_ok;

  assign lo_zext = {{(XLEN-WLEN){1'b0}}, src1[WLEN-1:0]};

  always_comb begin
    opnd_ok = 1'b1;
    case (fn)
      4'b0000: opnd_a = lo_zext;
      4'b0001: opnd_a = src1;
      4'b0010: opnd_a = {{(XLEN-1){1'b0}}, src1[0]};
      4'b0100, 4'b0101, 4'b0110, 4'b0111:
               opnd_a = src1 >> (SR_BASE + int'(fn[1:0]));
      4'b1000: opnd_a = lo_zext << 1;
      4'b1001: opnd_a = src1 << 1;
      4'b1010: opnd_a = lo_zext << 2;
      4'b1011: opnd_a = src1 << 2;
      4'b1100: opnd_a = lo_zext << 3;
      4'b1101: opnd_a = src1 << 3;
      4'b1111: opnd_a = src1 << 4;
      default: begin
        opnd_a  = '0;
        opnd_ok = 1'b0;
      end
    endcase
  end

  assign sum_sel = opnd_a + src2;
  assign add_res = opnd_ok ? sum_sel : '0;

  assign sum_raw = src1 + src2;
  assign odd_sum = {{(XLEN-1){1'b0}}, src1[0]} + src2;
  assign wdiff   = src1[WLEN-1:0] - src2[WLEN-1:0];

  always_comb begin
    case (fn)
      4'b0000: word_res = {{(XLEN-WLEN){sum_raw[WLEN-1]}}, sum_raw[WLEN-1:0]};
      4'b0001: word_res = {{(XLEN-WLEN){odd_sum[WLEN-1]}}, odd_sum[WLEN-1:0]};
      4'b0010: word_res = {{(XLEN-WLEN){wdiff[WLEN-1]}}, wdiff};
      4'b0100: word_res = {{(XLEN-1){1'b0}}, sum_raw[0]};
      4'b0101: word_res = {{(XLEN-BYTE){1'b0}}, sum_raw[BYTE-1:0]};
      4'b0110: word_res = {{(XLEN-HALF){1'b0}}, sum_raw[HALF-1:0]};
      4'b0111: word_res = {{(XLEN-HALF){sum_raw[HALF-1]}}, sum_raw[HALF-1:0]};
      default: word_res = '0;
    endcase
  end
endmodule

// File: rtl/bm_cmp_unit.sv
module bm_cmp_unit #(
  parameter int XLEN = 64
) (
  input  logic [3:0]      fn,
  input  logic [XLEN-1:0] src1,
  input  logic [XLEN-1:0] src2,
  output logic [XLEN-1:0] cmp_res
);
  logic [XLEN:0] wide_diff;
  logic          lt_u, lt_s;

  assign wide_diff = {1'b0, src1} - {1'b0, src2};
  assign lt_u      = wide_diff[XLEN];
  assign lt_s      = (src1[XLEN-1] != src2[XLEN-1]) ? src1[XLEN-1] : wide_diff[XLEN-1];

  always_comb begin
    case (fn)
      4'b0000: cmp_res = wide_diff[XLEN-1:0];
      4'b0001: cmp_res = {{(XLEN-1){1'b0}}, lt_u};
      4'b0010: cmp_res = {{(XLEN-1){1'b0}}, lt_s};
      4'b0100: cmp_res = lt_u ? src2 : src1;
      4'b0101: cmp_res = lt_u ? src1 : src2;
      4'b0110: cmp_res = lt_s ? src2 : src1;
      4'b0111: cmp_res = lt_s ? src1 : src2;
      default: cmp_res = '0;
    endcase
  end
endmodule

// File: rtl/bm_logic_unit.sv
module bm_logic_unit #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [3:0]      fn,
  input  logic [XLEN-1:0] src1,
  input  logic [XLEN-1:0] src2,
  output logic [XLEN-1:0] logic_res,
  output logic [XLEN-1:0] misc_res,
  output logic [XLEN-1:0] fused_res
);
  localparam int NBYTES = XLEN / 8;
  localparam int HALF   = 16;

  logic [XLEN-1:0] byte_or, byte_rev, opnd_b, bitwise, fused_pre;

  genvar gb;
  generate
    for (gb = 0; gb < NBYTES; gb++) begin : g_byte
      assign byte_or[8*gb +: 8]  = {8{|src1[8*gb +: 8]}};
      assign byte_rev[8*gb +: 8] = src1[XLEN-8-8*gb +: 8];
    end
  endgenerate

  assign opnd_b = fn[0] ? ~src2 : src2;

  always_comb begin
    case (fn[2:1])
      2'b00:   bitwise = src1 & opnd_b;
      2'b01:   bitwise = src1 | opnd_b;
      default: bitwise = src1 ^ opnd_b;
    endcase
  end

  always_comb begin
    case (fn)
      4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101:
               logic_res = bitwise;
      4'b0110: logic_res = byte_or;
      4'b1000: logic_res = {{(XLEN-8){src1[7]}}, src1[7:0]};
      4'b1001: logic_res = {{(XLEN-16){1'b0}}, src2[7:0], src1[7:0]};
      4'b1010: logic_res = {{(XLEN-HALF){src1[HALF-1]}}, src1[HALF-1:0]};
      4'b1011: logic_res = {{(XLEN-WLEN){src2[HALF-1]}}, src2[HALF-1:0], src1[HALF-1:0]};
      default: logic_res = '0;
    endcase
  end

  always_comb begin
    case (fn)
      4'b0001: misc_res = byte_rev;
      4'b0010: misc_res = {src2[WLEN-1:0], src1[WLEN-1:0]};
      default: misc_res = '0;
    endcase
  end

  always_comb begin
    case (fn[2:1])
      2'b00:   fused_pre = src1 & src2;
      2'b01:   fused_pre = src1 | src2;
      2'b10:   fused_pre = src1 ^ src2;
      default: fused_pre = byte_or;
    endcase
    if (fn[3])
      fused_res = '0;
    else if (fn[0])
      fused_res = {{(XLEN-HALF){1'b0}}, fused_pre[HALF-1:0]};
    else
      fused_res = {{(XLEN-1){1'b0}}, fused_pre[0]};
  end
endmodule

// File: rtl/bmalu_top.sv
module bmalu_top
  import bmalu_pkg::*;
#(
  parameter int XLEN = XLEN_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OP_W-1:0] op,
  input  logic [XLEN-1:0] src1,
  input  logic [XLEN-1:0] src2,
  output logic            out_valid,
  output logic [XLEN-1:0] result
);
  localparam int SHW = $clog2(XLEN);

  alu_grp_e        grp;
  logic [3:0]      fn;
  logic [XLEN-1:0] sh_base, sh_word, ad_add, ad_word, cmp_v, lg_v, misc_v, fz_v, res_next;

  assign grp = alu_grp_e'(op[6:4]);
  assign fn  = op[3:0];

  bm_shift_unit #(.XLEN(XLEN), .WLEN(WORD_W)) u_shift (
    .fn(fn), .src1(src1), .shamt(src2[SHW-1:0]),
    .base_res(sh_base), .word_res(sh_word)
  );

  bm_add_unit #(.XLEN(XLEN), .WLEN(WORD_W)) u_add (
    .fn(fn), .src1(src1), .src2(src2),
    .add_res(ad_add), .word_res(ad_word)
  );

  bm_cmp_unit #(.XLEN(XLEN)) u_cmp (
    .fn(fn), .src1(src1), .src2(src2), .cmp_res(cmp_v)
  );

  bm_logic_unit #(.XLEN(XLEN), .WLEN(WORD_W)) u_logic (
    .fn(fn), .src1(src1), .src2(src2),
    .logic_res(lg_v), .misc_res(misc_v), .fused_res(fz_v)
  );

  always_comb begin
    case (grp)
      GRP_SHIFT: res_next = sh_base;
      GRP_WORD:  res_next = fn[3] ? sh_word : ad_word;
      GRP_ADD:   res_next = ad_add;
      GRP_CMP:   res_next = cmp_v;
      GRP_LOGIC: res_next = lg_v;
      GRP_MISC:  res_next = misc_v;
      GRP_FUSED: res_next = fz_v;
      default:   res_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= res_next;
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));
  a_r4_word_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[6:4] == 3'b001) |=> (result[XLEN-1:WORD_W] == {(XLEN-WORD_W){result[WORD_W-1]}}));
  a_r9_flag_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 7'b0110001 || op == 7'b0110010)) |=> (result[XLEN-1:1] == '0));
  a_r9_minmax_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[6:2] == 5'b01101) |=> (result == $past(src1) || result == $past(src2)));
  a_r12_fused_half: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[6:4] == 3'b110) |=> (result[XLEN-1:16] == '0));
  a_r12_fused_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[6:4] == 3'b110 && !op[0]) |=> (result[XLEN-1:1] == '0));
  a_r13_top_group_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[6:4] == 3'b111) |=> (result == '0));
endmodule

// File: tb/bmalu_top_test.sv
`timescale 1ns/1ps
module bmalu_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [6:0]  op;
  logic [63:0] src1, src2;
  logic        out_valid;
  logic [63:0] result;

  int total = 0;
  int bad   = 0;

  logic        m_vld;
  logic [63:0] m_res;
  string       m_tag;
  logic [63:0] lfsr;

  always #4 clk = ~clk;

  bmalu_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src1(src1), .src2(src2), .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] sx32(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  function automatic logic [63:0] orc(input logic [63:0] a);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = (a[8*i +: 8] != 8'h00) ? 8'hFF : 8'h00;
    return r;
  endfunction

  function automatic logic [63:0] ref_model(input logic [6:0] o, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r, t, s;
    logic [31:0] w, wa;
    int sh, shw;
    sh  = int'(b[5:0]);
    shw = int'(b[4:0]);
    wa  = a[31:0];
    s   = a + b;
    r   = 64'd0;
    case (o)
      7'h00: r = {32'd0, wa} << sh;
      7'h01: r = a << sh;
      7'h02: r = a & ~(64'd1 << sh);
      7'h03: r = a | (64'd1 << sh);
      7'h04: r = a ^ (64'd1 << sh);
      7'h05: r = a >> sh;
      7'h06: r = {63'd0, a[sh]};
      7'h07: r = $signed(a) >>> sh;
      7'h09: r = (a << sh) | (a >> (64 - sh));
      7'h0B: r = (a >> sh) | (a << (64 - sh));
      7'h10: r = sx32(s[31:0]);
      7'h11: begin t = {63'd0, a[0]} + b; r = sx32(t[31:0]); end
      7'h12: begin w = wa - b[31:0]; r = sx32(w); end
      7'h14: r = {63'd0, s[0]};
      7'h15: r = s & 64'hFF;
      7'h16: r = s & 64'hFFFF;
      7'h17: r = {{48{s[15]}}, s[15:0]};
      7'h18: begin w = wa << shw; r = sx32(w); end
      7'h19: begin w = wa >> shw; r = sx32(w); end
      7'h1A: begin w = $signed(wa) >>> shw; r = sx32(w); end
      7'h1C: begin w = (wa << shw) | (wa >> (32 - shw)); r = sx32(w); end
      7'h1D: begin w = (wa >> shw) | (wa << (32 - shw)); r = sx32(w); end
      7'h20: r = {32'd0, wa} + b;
      7'h21: r = s;
      7'h22: r = {63'd0, a[0]} + b;
      7'h24, 7'h25, 7'h26, 7'h27: r = (a >> (29 + int'(o[1:0]))) + b;
      7'h28: r = ({32'd0, wa} << 1) + b;
      7'h29: r = (a << 1) + b;
      7'h2A: r = ({32'd0, wa} << 2) + b;
      7'h2B: r = (a << 2) + b;
      7'h2C: r = ({32'd0, wa} << 3) + b;
      7'h2D: r = (a << 3) + b;
      7'h2F: r = (a << 4) + b;
      7'h30: r = a - b;
      7'h31: r = (a < b) ? 64'd1 : 64'd0;
      7'h32: r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
      7'h34: r = (a > b) ? a : b;
      7'h35: r = (a < b) ? a : b;
      7'h36: r = ($signed(a) > $signed(b)) ? a : b;
      7'h37: r = ($signed(a) < $signed(b)) ? a : b;
      7'h40: r = a & b;
      7'h41: r = a & ~b;
      7'h42: r = a | b;
      7'h43: r = a | ~b;
      7'h44: r = a ^ b;
      7'h45: r = ~(a ^ b);
      7'h46: r = orc(a);
      7'h48: r = {{56{a[7]}}, a[7:0]};
      7'h49: r = {48'd0, b[7:0], a[7:0]};
      7'h4A: r = {{48{a[15]}}, a[15:0]};
      7'h4B: r = sx32({b[15:0], a[15:0]});
      7'h51: for (int i = 0; i < 8; i++) r[8*i +: 8] = a[56-8*i +: 8];
      7'h52: r = {b[31:0], wa};
      7'h60, 7'h61, 7'h62, 7'h63, 7'h64, 7'h65, 7'h66, 7'h67: begin
        case (o[2:1])
          2'd0: t = a & b;
          2'd1: t = a | b;
          2'd2: t = a ^ b;
          default: t = orc(a);
        endcase
        r = o[0] ? (t & 64'hFFFF) : (t & 64'h1);
      end
      default: r = 64'd0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [6:0] o);
    case (o)
      7'h00, 7'h01, 7'h05, 7'h07, 7'h09, 7'h0B: return "R2";
      7'h02, 7'h03, 7'h04, 7'h06: return "R3";
      7'h10, 7'h11, 7'h12, 7'h18, 7'h19, 7'h1A, 7'h1C, 7'h1D: return "R4";
      7'h14, 7'h15, 7'h16, 7'h17: return "R5";
      7'h20, 7'h21, 7'h22: return "R6";
      7'h28, 7'h29, 7'h2A, 7'h2B, 7'h2C, 7'h2D, 7'h2F: return "R7";
      7'h24, 7'h25, 7'h26, 7'h27: return "R8";
      7'h30, 7'h31, 7'h32, 7'h34, 7'h35, 7'h36, 7'h37: return "R9";
      7'h40, 7'h41, 7'h42, 7'h43, 7'h44, 7'h45, 7'h46: return "R10";
      7'h48, 7'h49, 7'h4A, 7'h4B, 7'h51, 7'h52: return "R11";
      7'h60, 7'h61, 7'h62, 7'h63, 7'h64, 7'h65, 7'h66, 7'h67: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic check_now();
    total++;
    if (out_valid !== m_vld) begin
      bad++;
      $display("FAIL R1 out_valid actual=%0b expected=%0b", out_valid, m_vld);
    end
    total++;
    if (result !== m_res) begin
      bad++;
      $display("FAIL %s result actual=%h expected=%h", m_tag, result, m_res);
    end
  endtask

  task automatic step(input logic v, input logic [6:0] o, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    check_now();
    in_valid = v;
    op       = o;
    src1     = a;
    src2     = b;
    m_vld    = v;
    if (v) begin
      m_res = ref_model(o, a, b);
      m_tag = tag_of(o);
    end else begin
      m_tag = "R1";
    end
  endtask

  function automatic logic [63:0] next_rand(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] a, b;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    op       = 7'h00;
    src1     = 64'd0;
    src2     = 64'd0;
    m_vld    = 1'b0;
    m_res    = 64'd0;
    m_tag    = "R1";
    lfsr     = 64'h9E37_79B9_7F4A_7C15;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_now();
    rst_n = 1'b1;

    for (int code = 0; code < 128; code++) begin
      for (int p = 0; p < 8; p++) begin
        case (p)
          0: begin a = 64'd0; b = 64'd0; end
          1: begin a = '1; b = 64'd5; end
          2: begin a = 64'h8000_0000_8000_0001; b = 64'd63; end
          3: begin a = 64'h0000_0000_FFFF_FFFF; b = 64'h8000_0000_0000_001F; end
          4: begin a = 64'h1234_5678_9ABC_DEF0; b = 64'h0000_00FF_0000_0020; end
          default: begin
            lfsr = next_rand(lfsr); a = lfsr;
            lfsr = next_rand(lfsr); b = lfsr;
          end
        endcase
        step(1'b1, 7'(code), a, b);
        if (p == 3) step(1'b0, 7'(code ^ 5), ~a, ~b); // R1 hold while idle
      end
    end
    step(1'b0, 7'h00, 64'd0, 64'd0);
    step(1'b0, 7'h21, 64'd1, 64'd1);
    @(negedge clk);
    check_now();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule